// File: doc/BRIEF.md
# Change-of-Flow Trace Capture Controller

This block sits beside a small 8-bit processor core and records the targets of its change-of-flow events (taken branches, jumps, calls, returns). Each event brings an address and a flag that marks a program-space access. While the trace is both turned on and armed, each qualifying event becomes one write toward an external capture FIFO, and the block keeps count of how many entries it has written. When the count reaches the FIFO depth, the run is over: the arm bit drops. If breaks are enabled, a break request goes to the CPU at that point, marked either as tagged or as forced.

An 8-bit control byte holds the settings. With loop-suppress mode on, the block remembers the most recently stored address in an internal compare register. A repeat of that address is then dropped, so a tight loop does not flood the FIFO. Outside that mode, a hit on the same compare register may itself raise a break. A security input keeps the trace turned off. A warm-reset input either keeps a finished trace for readout or clears everything, depending on how the run was configured.

Top module: `cof_trace_ctl`

## Requirements
- R1: The control byte reads bit 7 = enable, bit 6 = arm, bit 5 = tag select, bit 4 = break enable and bit 0 = loop-suppress. Bits 3..1 always read 0. A write loads all five fields in one cycle.
- R2: While `secure_i` is 1, enable reads 0 from the following cycle on, and a write cannot set it.
- R3: A power-on reset (`rst_n` low) clears every control field, sets the count to 0, and holds `fifo_wr_o` and `brk_req_o` low.
- R4: A warm reset (`soft_rst_i`) behaves in one of two ways. If enable is 1 and `begin_trig_i` is 0, it clears only arm and break enable, and the other fields and the count are kept. Otherwise it clears all fields and sets the count to 0.
- R5: An event on `cof_valid_i` is captured only while enable and arm are both 1. A capture drives `fifo_wr_o` high for exactly the next cycle, with `fifo_wdata_o` = {prog flag, address} (the flag in the MSB), and adds one to the count.
- R6: With loop-suppress off, every qualifying event is written, including repeats of the same address.
- R7: With loop-suppress on, an address equal to the stored compare address is dropped: no write and no count change. Any other address is written and also becomes the new compare address.
- R8: While `event_only_i` is 1, loop-suppress has no effect. Repeats are written, and the compare address is not reloaded.
- R9: The count never goes above DEPTH (8). The capture that fills the FIFO clears arm, and further events are not written.
- R10: If break enable is 1, the capture that fills the FIFO drives `brk_req_o` high for one cycle, and `brk_tag_o` then shows the tag select bit (1 = tagged, 0 = forced). If break enable is 0, no request is made.
- R11: A second kind of break is a compare hit. When loop-suppress is off, break enable is 1 and a compare address is held, a captured address equal to it raises a one-cycle `brk_req_o`.
- R12: A write that moves arm from 0 to 1 resets the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| reg_wr_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Control byte read data |
| secure_i | input | 1 | Security lock; keeps enable at 0 |
| soft_rst_i | input | 1 | Warm (non power-on) reset pulse |
| begin_trig_i | input | 1 | 1 when the run was configured to start at its trigger |
| event_only_i | input | 1 | 1 when capture is in an event-only mode |
| cof_valid_i | input | 1 | Change-of-flow event strobe |
| cof_addr_i | input | ADDR_W | Change-of-flow target address |
| cof_prog_i | input | 1 | Program-space access flag of the event |
| fifo_wr_o | output | 1 | Capture FIFO write strobe |
| fifo_wdata_o | output | ADDR_W+1 | Capture FIFO entry {flag, address} |
| fifo_cnt_o | output | $clog2(DEPTH+1) | Entries written in this run |
| brk_req_o | output | 1 | One-cycle CPU break request |
| brk_tag_o | output | 1 | Kind of the last request: 1 tagged, 0 forced |

## Verification
The bench sends back-to-back repeats of the same address with loop-suppress both off and on. A design that compares against the wrong address, or forgets to reload it, writes a loop that should be dropped or drops a fresh address, and the scoreboard sees the extra or missing entry. It runs a fill to exactly eight entries and then one more event, which catches a count that wraps, a run that never disarms, or a break that is missing or carries the wrong tag. The two warm-reset cases are checked against each other, so that a design that clears too much or too little of the control byte, or loses the count, shows up in the read value.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

  localparam int unsigned CTL_W    = 8;
  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_ARM  = 6;
  localparam int unsigned BIT_TAG  = 5;
  localparam int unsigned BIT_BRK  = 4;
  localparam int unsigned BIT_LOOP = 0;

  typedef struct packed {
    logic en;
    logic arm;
    logic tag;
    logic brk;
    logic loop;
  } ctl_t;

  function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
    logic [CTL_W-1:0] b;
    b           = '0;
    b[BIT_EN]   = c.en;
    b[BIT_ARM]  = c.arm;
    b[BIT_TAG]  = c.tag;
    b[BIT_BRK]  = c.brk;
    b[BIT_LOOP] = c.loop;
    return b;
  endfunction

  function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] b);
    ctl_t c;
    c.en   = b[BIT_EN];
    c.arm  = b[BIT_ARM];
    c.tag  = b[BIT_TAG];
    c.brk  = b[BIT_BRK];
    c.loop = b[BIT_LOOP];
    return c;
  endfunction

endpackage

// File: rtl/cof_ctl_reg.sv
module cof_ctl_reg
  import cof_trace_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             secure_i,
  input  logic             soft_rst_i,
  input  logic             begin_trig_i,
  input  logic             run_end_i,
  output ctl_t             ctl_o,
  output logic             arm_rise_o,
  output logic             hard_clr_o,
  output logic [CTL_W-1:0] rdata_o
);

  ctl_t ctl_q, ctl_d;
  logic ctl_ld;
  logic keep_run;

  assign keep_run = ctl_q.en && !begin_trig_i;

  always_comb begin
    ctl_d = ctl_q;
    if (soft_rst_i) begin
      if (keep_run) begin
        ctl_d.arm = 1'b0;
        ctl_d.brk = 1'b0;
      end else begin
        ctl_d = '0;
      end
    end else begin
      if (wr_i)      ctl_d     = ctl_unpack(wdata_i);
      if (run_end_i) ctl_d.arm = 1'b0;
    end
    if (secure_i) ctl_d.en = 1'b0;
  end

  assign ctl_ld     = soft_rst_i || wr_i || run_end_i || secure_i;
  assign arm_rise_o = !soft_rst_i && wr_i && wdata_i[BIT_ARM] && !ctl_q.arm;
  assign hard_clr_o = soft_rst_i && !keep_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ld) ctl_q <= ctl_d;
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = ctl_pack(ctl_q);

endmodule

// File: rtl/cof_loop_filter.sv
module cof_loop_filter #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              qual_i,
  input  logic              loop_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              store_o,
  output logic              cmatch_o
);

  logic [ADDR_W-1:0] cmp_q;
  logic              cmp_vld_q, cmp_vld_d;
  logic              hit, load;

  assign hit      = cmp_vld_q && (addr_i == cmp_q);
  assign store_o  = qual_i && !(loop_i && hit);
  assign cmatch_o = qual_i && !loop_i && hit;
  assign load     = qual_i && loop_i && !hit;

  always_comb begin
    cmp_vld_d = cmp_vld_q;
    if (clr_i)     cmp_vld_d = 1'b0;
    else if (load) cmp_vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_vld_q <= 1'b0;
    else        cmp_vld_q <= cmp_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= '0;
    else if (load) cmp_q <= addr_i;
  end

endmodule

// File: rtl/cof_fill_ctr.sv
module cof_fill_ctr #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned ENT_W = 17,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             store_i,
  input  logic [ENT_W-1:0] entry_i,
  input  logic             brken_i,
  input  logic             tag_i,
  input  logic             cmatch_i,
  output logic             run_end_o,
  output logic             fifo_wr_o,
  output logic [ENT_W-1:0] fifo_wdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             brk_req_o,
  output logic             brk_tag_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, full;
  logic             wr_q, brk_q, brk_d, tag_q;
  logic [ENT_W-1:0] data_q;

  assign full      = (cnt_q == CNT_FULL);
  assign accept    = store_i && !full && !clr_i;
  assign run_end_o = accept && (cnt_q == CNT_LAST);
  assign brk_d     = brken_i && (run_end_o || (cmatch_i && accept));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (accept) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wr_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      wr_q  <= accept;
      brk_q <= brk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= entry_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tag_q <= 1'b0;
    else if (brk_d) tag_q <= tag_i;
  end

  assign cnt_o        = cnt_q;
  assign fifo_wr_o    = wr_q;
  assign fifo_wdata_o = data_q;
  assign brk_req_o    = brk_q;
  assign brk_tag_o    = tag_q;

endmodule

// File: rtl/cof_trace_ctl.sv
module cof_trace_ctl
  import cof_trace_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ENT_W = ADDR_W + 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              secure_i,
  input  logic              soft_rst_i,
  input  logic              begin_trig_i,
  input  logic              event_only_i,
  input  logic              cof_valid_i,
  input  logic [ADDR_W-1:0] cof_addr_i,
  input  logic              cof_prog_i,
  output logic              fifo_wr_o,
  output logic [ENT_W-1:0]  fifo_wdata_o,
  output logic [CNT_W-1:0]  fifo_cnt_o,
  output logic              brk_req_o,
  output logic              brk_tag_o
);

  ctl_t ctl;
  logic arm_rise, hard_clr, run_end;
  logic qual, loop_eff, store, cmatch;

  assign qual     = cof_valid_i && ctl.en && ctl.arm && !soft_rst_i;
  assign loop_eff = ctl.loop && !event_only_i;

  cof_ctl_reg u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (reg_wr_i),
    .wdata_i      (reg_wdata_i),
    .secure_i     (secure_i),
    .soft_rst_i   (soft_rst_i),
    .begin_trig_i (begin_trig_i),
    .run_end_i    (run_end),
    .ctl_o        (ctl),
    .arm_rise_o   (arm_rise),
    .hard_clr_o   (hard_clr),
    .rdata_o      (reg_rdata_o)
  );

  cof_loop_filter #(.ADDR_W(ADDR_W)) u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (hard_clr),
    .qual_i   (qual),
    .loop_i   (loop_eff),
    .addr_i   (cof_addr_i),
    .store_o  (store),
    .cmatch_o (cmatch)
  );

  cof_fill_ctr #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (hard_clr || arm_rise),
    .store_i      (store),
    .entry_i      ({cof_prog_i, cof_addr_i}),
    .brken_i      (ctl.brk),
    .tag_i        (ctl.tag),
    .cmatch_i     (cmatch),
    .run_end_o    (run_end),
    .fifo_wr_o    (fifo_wr_o),
    .fifo_wdata_o (fifo_wdata_o),
    .cnt_o        (fifo_cnt_o),
    .brk_req_o    (brk_req_o),
    .brk_tag_o    (brk_tag_o)
  );

endmodule

// File: rtl/cof_trace_ctl_chk.sv
module cof_trace_ctl_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             secure_i,
  input logic             cof_valid_i,
  input logic [7:0]       reg_rdata_o,
  input logic             fifo_wr_o,
  input logic [CNT_W-1:0] fifo_cnt_o,
  input logic             brk_req_o
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[3:1] == 3'b000); // R1

  AST_SECURE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    secure_i |=> !reg_rdata_o[7]); // R2

  AST_WR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |-> $past(cof_valid_i && reg_rdata_o[7] && reg_rdata_o[6])); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |-> (fifo_cnt_o == CNT_W'($past(fifo_cnt_o) + 1'b1))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt_o <= CNT_W'(DEPTH)); // R9

  AST_FULL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_cnt_o == CNT_W'(DEPTH)) |-> !reg_rdata_o[6]); // R9

  AST_BRK_NEEDS_BRKEN: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req_o |-> $past(reg_rdata_o[4])); // R10

endmodule

bind cof_trace_ctl cof_trace_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .secure_i    (secure_i),
  .cof_valid_i (cof_valid_i),
  .reg_rdata_o (reg_rdata_o),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_cnt_o  (fifo_cnt_o),
  .brk_req_o   (brk_req_o)
);

// File: tb/cof_trace_ctl_bench.sv
module cof_trace_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        secure_i = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        begin_trig_i = 1'b0;
  logic        event_only_i = 1'b0;
  logic        cof_valid_i = 1'b0;
  logic [15:0] cof_addr_i = '0;
  logic        cof_prog_i = 1'b0;
  logic        fifo_wr_o;
  logic [16:0] fifo_wdata_o;
  logic [3:0]  fifo_cnt_o;
  logic        brk_req_o;
  logic        brk_tag_o;

  int checks = 0;
  int fails = 0;
  int brk_cnt = 0;
  int exp_cnt = 0;
  logic last_tag = 1'b0;
  logic [16:0] sb_q[$];

  cof_trace_ctl u_cof_trace_ctl (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected entries as the design writes them
  always @(negedge clk) begin
    if (rst_n && fifo_wr_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R5/R6/R7 unexpected write", int'(fifo_wdata_o), 0);
      end else begin
        logic [16:0] e;
        e = sb_q.pop_front();
        chk(fifo_wdata_o == e, "R5 entry", int'(fifo_wdata_o), int'(e));
      end
    end
    if (rst_n && brk_req_o) begin
      brk_cnt++;
      last_tag = brk_tag_o;
    end
  end

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 1'b0; #1;
  endtask

  task automatic cof(input logic [15:0] a, input logic p, input bit st, input string req);
    @(negedge clk); cof_valid_i = 1'b1; cof_addr_i = a; cof_prog_i = p;
    if (st) begin sb_q.push_back({p, a}); exp_cnt++; end
    @(negedge clk); cof_valid_i = 1'b0; #1;
    chk(fifo_cnt_o == 4'(exp_cnt), req, int'(fifo_cnt_o), exp_cnt);
  endtask

  task automatic soft_pulse(input logic bt);
    @(negedge clk); soft_rst_i = 1'b1; begin_trig_i = bt;
    @(negedge clk); soft_rst_i = 1'b0; begin_trig_i = 1'b0; #1;
  endtask

  task automatic drained(input string req);
    chk(sb_q.size() == 0, req, sb_q.size(), 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // R3 reset state
    chk(reg_rdata_o == 8'h00, "R3 ctl after reset", reg_rdata_o, 0);
    chk(fifo_cnt_o == 0 && !fifo_wr_o && !brk_req_o, "R3 outputs after reset", fifo_cnt_o, 0);

    // R1 field layout
    wr_ctl(8'hFF);
    chk(reg_rdata_o == 8'hF1, "R1 read layout", reg_rdata_o, 8'hF1);
    wr_ctl(8'h00);

    // R2 security
    secure_i = 1'b1;
    wr_ctl(8'h80);
    chk(reg_rdata_o[7] == 1'b0, "R2 write blocked", reg_rdata_o, 0);
    secure_i = 1'b0;
    wr_ctl(8'h80);
    secure_i = 1'b1;
    @(negedge clk); #1;
    chk(reg_rdata_o[7] == 1'b0, "R2 enable forced off", reg_rdata_o, 0);
    secure_i = 1'b0;

    // R5 not armed: no capture
    wr_ctl(8'h80);
    cof(16'h0010, 1'b1, 1'b0, "R5 unarmed ignored");

    // R6 loop off, repeats written
    wr_ctl(8'hC0);
    cof(16'h0100, 1'b1, 1'b1, "R6 first");
    cof(16'h0100, 1'b1, 1'b1, "R6 repeat");
    cof(16'h0104, 1'b0, 1'b1, "R6 other");
    drained("R6 all entries written");

    // R7 loop on
    wr_ctl(8'hC1);
    cof(16'h0100, 1'b1, 1'b1, "R7 new address");
    cof(16'h0100, 1'b1, 1'b0, "R7 loop dropped");
    cof(16'h0200, 1'b0, 1'b1, "R7 reload");
    cof(16'h0200, 1'b0, 1'b0, "R7 loop dropped again");
    drained("R7 entries");

    // R8 event-only ignores loop-suppress
    event_only_i = 1'b1;
    cof(16'h0200, 1'b0, 1'b1, "R8 repeat written");
    event_only_i = 1'b0;
    drained("R8 entries");

    // R12 re-arm resets count
    wr_ctl(8'h80);
    wr_ctl(8'hC0);
    exp_cnt = 0;
    chk(fifo_cnt_o == 0, "R12 count reset on arm", fifo_cnt_o, 0);

    // R11 compare hit break with loop off (compare holds 0x0200)
    wr_ctl(8'hD0);
    cof(16'h0200, 1'b1, 1'b1, "R11 hit captured");
    chk(brk_cnt == 1 && last_tag == 1'b0, "R11 compare break forced", brk_cnt, 1);

    // R9/R10 fill to full with tagged break
    wr_ctl(8'hF0);
    for (int i = 0; i < 7; i++) cof(16'h0300 + 16'(i), 1'b1, 1'b1, "R9 fill");
    chk(brk_cnt == 2 && last_tag == 1'b1, "R10 tagged break at full", brk_cnt, 2);
    chk(reg_rdata_o == 8'hB0, "R9 arm cleared at full", reg_rdata_o, 8'hB0);
    cof(16'h0399, 1'b1, 1'b0, "R9 saturated");
    drained("R9 entries");

    // R10 no break when break enable is 0
    wr_ctl(8'h80);
    wr_ctl(8'hC0);
    exp_cnt = 0;
    for (int i = 0; i < 8; i++) cof(16'h0400 + 16'(i), 1'b0, 1'b1, "R10 fill no brk");
    chk(brk_cnt == 2, "R10 no request without break enable", brk_cnt, 2);
    chk(reg_rdata_o == 8'h80, "R9 disarm", reg_rdata_o, 8'h80);

    // R4 warm reset keeping the run
    wr_ctl(8'hF1);
    exp_cnt = 0;
    cof(16'h0500, 1'b1, 1'b1, "R4 setup");
    cof(16'h0501, 1'b1, 1'b1, "R4 setup");
    soft_pulse(1'b0);
    chk(reg_rdata_o == 8'hA1, "R4 keep run ctl", reg_rdata_o, 8'hA1);
    chk(fifo_cnt_o == 2, "R4 keep run count", fifo_cnt_o, 2);
    soft_pulse(1'b1);
    chk(reg_rdata_o == 8'h00, "R4 full clear ctl", reg_rdata_o, 0);
    chk(fifo_cnt_o == 0, "R4 full clear count", fifo_cnt_o, 0);
    exp_cnt = 0;

    // R3 power-on reset mid run
    wr_ctl(8'hF1);
    cof(16'h0600, 1'b0, 1'b1, "R3 setup");
    @(negedge clk); rst_n = 1'b0; #1;
    chk(reg_rdata_o == 8'h00 && fifo_cnt_o == 0, "R3 reset mid run", fifo_cnt_o, 0);
    @(negedge clk); rst_n = 1'b1;
    drained("R3 entries");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule